// File: doc/BRIEF.md
# Shader Program Sequencer Cluster

This block steers three small programmable vector processors through one shared program. Each of the three sequencer instances keeps its own program counter, subroutine return stack and loop stack. Each instance fetches one instruction per cycle from an on-chip store of 256 words. Control-flow instructions are resolved inside the sequencer. Every other instruction is handed unchanged to an external vector ALU. Conditions can come from a flag the ALU computed during the run, from one of sixteen externally loaded one-bit flag registers, or from neither. Because of this, two vertices running the same program may follow different paths.

Work is issued in batches of up to three vertices. A `start` pulse, taken only while the cluster is idle, launches every instance whose `vertex_valid` bit is set, all in the same cycle. An instance that finishes early waits until the others are done. A single-cycle `done` pulse then closes the batch. A runaway program is cut off after a fixed number of executed instructions. The program store and the counter and flag registers are written through a word-wide load port that only works between batches.

Top module: `seq_cluster`

## Requirements
- R1: After reset, `busy`, `done`, `error` and `alu_valid` are all 0, and every executed-instruction count and last-PC field reads 0.
- R2: A load write with `load_we`=1 targets a region chosen by `load_addr[9:8]`. Region 0 writes program word `load_addr[7:0]` with the 32-bit data. Region 1 writes counter register `load_addr[3:0]` with `load_data[7:0]`. Region 2 writes flag register `load_addr[3:0]` with `load_data[0]`. Any write made while `busy` is 1 is discarded.
- R3: An instruction word has its opcode in bits [31:28]. Opcodes 8 to 15 are ALU operations: each one raises `alu_valid` for that instance for one cycle and shows the unchanged word on `alu_instr`. Opcode 0 (no-op), 7 (reserved) and the control opcodes never raise `alu_valid`.
- R4: Opcode 1 is a conditional jump to the target in bits [7:0]. The condition source in bits [27:26] selects always (0), the instance's `alu_flag` input (1), flag register [19:16] (2) or never (3). Bit 25 inverts the condition.
- R5: Opcode 2 is a conditional call: it pushes the address after itself and jumps to the target. Opcode 3 returns to the most recently pushed address. Calls may nest four deep.
- R6: Opcode 4 opens a loop using counter register [19:16], which holds a value v. The body runs up to the matching opcode 5 and executes v+1 times, so v=255 gives 256 passes. Loops may nest four deep.
- R7: Opcode 6 ends the run when its condition is true. The run also ends after an instruction at address 255 that does not transfer control elsewhere.
- R8: The run ends once 65536 instructions have been executed. Every loop pass and every taken jump is counted.
- R9: A call or loop entry while its 4-deep stack is full, a return with no pending call, or a loop close with no open loop sets that instance's `error` bit and ends its run. The bit holds until the next accepted `start`.
- R10: `start` while idle launches all instances selected by `vertex_valid` together, and `busy` reads 1 from the next cycle. Unselected instances do not execute. When every instance has stopped, `busy` drops and `done` is 1 for exactly one cycle.
- R11: When a run ends, each instance's executed-instruction count and the address of the last instruction it executed are held on `exec_count` and `last_pc` until the next accepted `start`.
- R12: Each instance evaluates its own conditions, so instances in one batch may execute different numbers of instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Batch launch request, taken only while idle |
| vertex_valid | input | 3 | Instances that take part in the batch |
| load_we | input | 1 | Load port write strobe |
| load_addr | input | 10 | Load port region and address |
| load_data | input | 32 | Load port write data |
| alu_flag | input | 3 | Per-instance condition flag from the ALU |
| alu_valid | output | 3 | Per-instance ALU instruction issue strobe |
| alu_instr | output | 96 | Per-instance issued instruction word, instance 0 in the low 32 bits |
| busy | output | 1 | Batch in progress |
| done | output | 1 | One-cycle batch completion pulse |
| error | output | 3 | Per-instance sticky stack fault |
| exec_count | output | 51 | Per-instance executed-instruction count, 17 bits each |
| last_pc | output | 24 | Per-instance address of the last executed instruction, 8 bits each |

## Verification
Programs are chosen so that each one isolates a single control-flow mechanism:
- A straight run mixing ALU, reserved and no-op words separates what is issued from what is swallowed.
- A loop at its full count of 256, and nested loops with a count of zero, check the off-by-one rule for iteration counts.
- A jump on the ALU flag, with different flags per instance, shows that the paths are independent. A jump on an inverted flag register shows that source selection and inversion are decoded.
- Four-deep calls compare against a fifth call, an orphan return and a fifth loop entry, which tells legal nesting apart from a fault.
- A two-word endless loop reaches the instruction budget.
- An all-no-op store falls off the end of the program.
- A partial batch and a load attempted mid-batch confirm that absent vertices and writes made while busy change nothing.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int PC_W   = 8;
    localparam int IW     = 32;
    localparam int NREG   = 16;
    localparam int RIDX_W = 4;
    localparam int LCNT_W = 8;
    localparam int LA_W   = 10;

    typedef logic [PC_W-1:0] pc_t;

    // control opcodes; bit 3 set marks an ALU operation
    localparam logic [3:0] OP_NOP  = 4'h0;
    localparam logic [3:0] OP_JMP  = 4'h1;
    localparam logic [3:0] OP_CALL = 4'h2;
    localparam logic [3:0] OP_RET  = 4'h3;
    localparam logic [3:0] OP_LOOP = 4'h4;
    localparam logic [3:0] OP_ENDL = 4'h5;
    localparam logic [3:0] OP_STOP = 4'h6;

    // load port regions (load_addr[9:8])
    localparam logic [1:0] RG_PROG = 2'b00;
    localparam logic [1:0] RG_CNT  = 2'b01;
    localparam logic [1:0] RG_FLAG = 2'b10;

    typedef enum logic [1:0] {
        CS_ALWAYS = 2'd0,
        CS_ALU    = 2'd1,
        CS_FREG   = 2'd2,
        CS_NEVER  = 2'd3
    } csel_e;

    typedef struct packed {
        logic [3:0]        op;
        csel_e             csel;
        logic              inv;
        logic [4:0]        pad_hi;
        logic [RIDX_W-1:0] ridx;
        logic [7:0]        pad_lo;
        pc_t               tgt;
    } instr_t;

    typedef struct packed {
        pc_t               body;
        logic [LCNT_W-1:0] left;
    } loop_ent_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } seq_st_e;

    function automatic logic is_alu_op(logic [3:0] op);
        return op[3];
    endfunction

endpackage

// File: rtl/seq_stack.sv
module seq_stack #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         push,
    input  logic         pop,
    input  logic         upd,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] top,
    output logic         full,
    output logic         empty
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int PTR_W = $clog2(DEPTH + 1);
    localparam int SLOTS = 2 ** IDX_W;

    logic [W-1:0]     slot [SLOTS];
    logic [PTR_W-1:0] sp;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;

    assign wr_idx = sp[IDX_W-1:0];
    assign rd_idx = IDX_W'(sp - PTR_W'(1));
    assign top    = slot[rd_idx];
    assign full   = (sp == PTR_W'(DEPTH));
    assign empty  = (sp == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= '0;
            for (int i = 0; i < SLOTS; i++) slot[i] <= '0;
        end else if (clr) begin
            sp <= '0;
        end else if (push) begin
            slot[wr_idx] <= wdata;
            sp           <= sp + PTR_W'(1);
        end else if (pop) begin
            sp <= sp - PTR_W'(1);
        end else if (upd) begin
            slot[rd_idx] <= wdata;
        end
    end
endmodule

// File: rtl/seq_store.sv
module seq_store
    import seq_pkg::*;
#(
    parameter int NPORT = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [LA_W-1:0]             waddr,
    input  logic [IW-1:0]               wdata,
    input  logic [NPORT-1:0][PC_W-1:0]  rd_pc,
    output logic [NPORT-1:0][IW-1:0]    rd_word,
    output logic [NREG-1:0][LCNT_W-1:0] cnt_regs,
    output logic [NREG-1:0]             flag_regs
);
    localparam int WORDS = 2 ** PC_W;

    logic [IW-1:0]     prog [WORDS];
    logic [1:0]        region;
    logic [RIDX_W-1:0] ridx;

    assign region = waddr[LA_W-1:LA_W-2];
    assign ridx   = waddr[RIDX_W-1:0];

    always_ff @(posedge clk) begin
        if (we && region == RG_PROG) prog[waddr[PC_W-1:0]] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_regs  <= '0;
            flag_regs <= '0;
        end else if (we) begin
            if (region == RG_CNT)  cnt_regs[ridx]  <= wdata[LCNT_W-1:0];
            if (region == RG_FLAG) flag_regs[ridx] <= wdata[0];
        end
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_rd
        assign rd_word[g] = prog[rd_pc[g]];
    end
endmodule

// File: rtl/seq_core.sv
module seq_core
    import seq_pkg::*;
#(
    parameter int CNT_W    = 17,
    parameter int BUDGET   = 65536,
    parameter int CS_DEPTH = 4,
    parameter int LS_DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr,
    input  logic                        go,
    input  logic [IW-1:0]               instr_word,
    input  logic                        alu_flag,
    input  logic [NREG-1:0][LCNT_W-1:0] cnt_regs,
    input  logic [NREG-1:0]             flag_regs,
    output pc_t                         pc,
    output logic                        running,
    output logic                        alu_valid,
    output logic [IW-1:0]               alu_instr,
    output logic                        err,
    output logic [CNT_W-1:0]            exec_cnt,
    output pc_t                         last_pc
);
    localparam int LE_W = $bits(loop_ent_t);

    seq_st_e   state;
    instr_t    ins;
    logic      cond_raw, cond;
    pc_t       nxt, pc_inc;
    logic      seq, fault, stop;
    logic      cs_push, cs_pop, cs_full, cs_empty;
    pc_t       cs_top;
    logic      ls_push, ls_pop, ls_upd, ls_full, ls_empty;
    loop_ent_t ls_wdata, ls_top;
    logic [LE_W-1:0] ls_top_raw;

    assign ins       = instr_t'(instr_word);
    assign running   = (state == ST_RUN);
    assign alu_valid = running && is_alu_op(ins.op);
    assign alu_instr = ins;
    assign pc_inc    = pc + pc_t'(1);
    assign ls_top    = loop_ent_t'(ls_top_raw);

    always_comb begin
        unique case (ins.csel)
            CS_ALWAYS: cond_raw = 1'b1;
            CS_ALU:    cond_raw = alu_flag;
            CS_FREG:   cond_raw = flag_regs[ins.ridx];
            default:   cond_raw = 1'b0;
        endcase
        cond = cond_raw ^ ins.inv;
    end

    always_comb begin
        nxt           = pc_inc;
        seq           = 1'b1;
        fault         = 1'b0;
        stop          = 1'b0;
        cs_push       = 1'b0;
        cs_pop        = 1'b0;
        ls_push       = 1'b0;
        ls_pop        = 1'b0;
        ls_upd        = 1'b0;
        ls_wdata.body = pc_inc;
        ls_wdata.left = cnt_regs[ins.ridx];
        case (ins.op)
            OP_JMP: if (cond) begin
                nxt = ins.tgt;
                seq = 1'b0;
            end
            OP_CALL: if (cond) begin
                if (cs_full) fault = 1'b1;
                else begin
                    cs_push = 1'b1;
                    nxt     = ins.tgt;
                    seq     = 1'b0;
                end
            end
            OP_RET: begin
                if (cs_empty) fault = 1'b1;
                else begin
                    cs_pop = 1'b1;
                    nxt    = cs_top;
                    seq    = 1'b0;
                end
            end
            OP_LOOP: begin
                if (ls_full) fault = 1'b1;
                else ls_push = 1'b1;
            end
            OP_ENDL: begin
                if (ls_empty) fault = 1'b1;
                else if (ls_top.left == '0) ls_pop = 1'b1;
                else begin
                    ls_upd        = 1'b1;
                    ls_wdata.body = ls_top.body;
                    ls_wdata.left = ls_top.left - LCNT_W'(1);
                    nxt           = ls_top.body;
                    seq           = 1'b0;
                end
            end
            OP_STOP: if (cond) stop = 1'b1;
            default: ;
        endcase
        if (seq && pc == '1) stop = 1'b1;
        if (exec_cnt == CNT_W'(BUDGET - 1)) stop = 1'b1;
    end

    seq_stack #(.W(PC_W), .DEPTH(CS_DEPTH)) u_call_stk (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .push  (running && cs_push),
        .pop   (running && cs_pop),
        .upd   (1'b0),
        .wdata (pc_inc),
        .top   (cs_top),
        .full  (cs_full),
        .empty (cs_empty)
    );

    seq_stack #(.W(LE_W), .DEPTH(LS_DEPTH)) u_loop_stk (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .push  (running && ls_push),
        .pop   (running && ls_pop),
        .upd   (running && ls_upd),
        .wdata (ls_wdata),
        .top   (ls_top_raw),
        .full  (ls_full),
        .empty (ls_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            pc       <= '0;
            exec_cnt <= '0;
            last_pc  <= '0;
            err      <= 1'b0;
        end else if (clr) begin
            state    <= go ? ST_RUN : ST_IDLE;
            pc       <= '0;
            exec_cnt <= '0;
            last_pc  <= '0;
            err      <= 1'b0;
        end else if (running) begin
            exec_cnt <= exec_cnt + CNT_W'(1);
            last_pc  <= pc;
            pc       <= nxt;
            if (fault) err <= 1'b1;
            if (fault || stop) state <= ST_FIN;
        end
    end
endmodule

// File: rtl/seq_cluster.sv
module seq_cluster
    import seq_pkg::*;
#(
    parameter int NV       = 3,
    parameter int BUDGET   = 65536,
    parameter int CS_DEPTH = 4,
    parameter int LS_DEPTH = 4,
    localparam int CNT_W   = $clog2(BUDGET + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [NV-1:0]       vertex_valid,
    input  logic                load_we,
    input  logic [LA_W-1:0]     load_addr,
    input  logic [IW-1:0]       load_data,
    input  logic [NV-1:0]       alu_flag,
    output logic [NV-1:0]       alu_valid,
    output logic [NV*IW-1:0]    alu_instr,
    output logic                busy,
    output logic                done,
    output logic [NV-1:0]       error,
    output logic [NV*CNT_W-1:0] exec_count,
    output logic [NV*PC_W-1:0]  last_pc
);
    logic                        accept;
    logic [NV-1:0]               run_v;
    logic [NV-1:0][PC_W-1:0]     fetch_pc;
    logic [NV-1:0][IW-1:0]       fetch_word;
    logic [NREG-1:0][LCNT_W-1:0] cnt_regs;
    logic [NREG-1:0]             flag_regs;

    assign accept = start && !busy;

    seq_store #(.NPORT(NV)) u_store (
        .clk       (clk),
        .rst       (rst),
        .we        (load_we && !busy),
        .waddr     (load_addr),
        .wdata     (load_data),
        .rd_pc     (fetch_pc),
        .rd_word   (fetch_word),
        .cnt_regs  (cnt_regs),
        .flag_regs (flag_regs)
    );

    for (genvar g = 0; g < NV; g++) begin : g_inst
        seq_core #(
            .CNT_W    (CNT_W),
            .BUDGET   (BUDGET),
            .CS_DEPTH (CS_DEPTH),
            .LS_DEPTH (LS_DEPTH)
        ) u_core (
            .clk        (clk),
            .rst        (rst),
            .clr        (accept),
            .go         (vertex_valid[g]),
            .instr_word (fetch_word[g]),
            .alu_flag   (alu_flag[g]),
            .cnt_regs   (cnt_regs),
            .flag_regs  (flag_regs),
            .pc         (fetch_pc[g]),
            .running    (run_v[g]),
            .alu_valid  (alu_valid[g]),
            .alu_instr  (alu_instr[g*IW +: IW]),
            .err        (error[g]),
            .exec_cnt   (exec_count[g*CNT_W +: CNT_W]),
            .last_pc    (last_pc[g*PC_W +: PC_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy <= 1'b1;
            end else if (busy && run_v == '0) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/seq_cluster_chk.sv
module seq_cluster_chk
    import seq_pkg::*;
#(
    parameter int NV     = 3,
    parameter int CNT_W  = 17,
    parameter int BUDGET = 65536
) (
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic                busy,
    input logic                done,
    input logic [NV-1:0]       alu_valid,
    input logic [NV*IW-1:0]    alu_instr,
    input logic [NV-1:0]       error,
    input logic [NV*CNT_W-1:0] exec_count
);
    // R10
    done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    start_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R10
    busy_end_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R9
    error_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy) && !$past(start)) |-> $stable(error));

    for (genvar g = 0; g < NV; g++) begin : g_chk
        // R3
        alu_op_class_chk: assert property (@(posedge clk) disable iff (rst)
            alu_valid[g] |-> (alu_instr[g*IW + IW - 1] && $countones(alu_instr[g*IW +: IW]) > 0));

        // R8
        budget_cap_chk: assert property (@(posedge clk) disable iff (rst)
            exec_count[g*CNT_W +: CNT_W] <= CNT_W'(BUDGET));

        // R10
        idle_no_issue_chk: assert property (@(posedge clk) disable iff (rst)
            !busy |-> !alu_valid[g]);
    end
endmodule

bind seq_cluster seq_cluster_chk #(.NV(NV), .CNT_W(CNT_W), .BUDGET(BUDGET)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .alu_valid  (alu_valid),
    .alu_instr  (alu_instr),
    .error      (error),
    .exec_count (exec_count)
);

// File: tb/tb_seq_cluster.sv
module tb_seq_cluster;
    localparam int NV     = 3;
    localparam int BUDGET = 65536;
    localparam int CW     = 17;

    logic           clk = 1'b0;
    logic           rst;
    logic           start;
    logic [NV-1:0]  vertex_valid;
    logic           load_we;
    logic [9:0]     load_addr;
    logic [31:0]    load_data;
    logic [NV-1:0]  alu_flag;
    logic [NV-1:0]  alu_valid;
    logic [NV*32-1:0] alu_instr;
    logic           busy, done;
    logic [NV-1:0]  error;
    logic [NV*CW-1:0] exec_count;
    logic [NV*8-1:0]  last_pc;

    always #4 clk = ~clk;

    seq_cluster dut (
        .clk(clk), .rst(rst), .start(start), .vertex_valid(vertex_valid),
        .load_we(load_we), .load_addr(load_addr), .load_data(load_data),
        .alu_flag(alu_flag), .alu_valid(alu_valid), .alu_instr(alu_instr),
        .busy(busy), .done(done), .error(error),
        .exec_count(exec_count), .last_pc(last_pc)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] mem_sh [256];
    logic [7:0]  creg_sh [16];
    logic        freg_sh [16];
    int alu_seen [NV];
    int alu_badop [NV];

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(int op, int cs, int inv, int ridx, int tgt);
        return {4'(op), 2'(cs), 1'(inv), 5'd0, 4'(ridx), 8'd0, 8'(tgt)};
    endfunction

    function automatic logic [31:0] alu_w(int k);
        return 32'h9000_0000 | 32'(k) | (32'(k & 7) << 28) | 32'h0050_0A00;
    endfunction

    always @(negedge clk) begin
        for (int i = 0; i < NV; i++) begin
            if (alu_valid[i]) begin
                alu_seen[i]++;
                if (!alu_instr[i*32+31]) alu_badop[i]++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    task automatic clear_shadow(logic [31:0] fill);
        for (int a = 0; a < 256; a++) mem_sh[a] = fill;
        for (int r = 0; r < 16; r++) begin
            creg_sh[r] = 8'd0;
            freg_sh[r] = 1'b0;
        end
    endtask

    task automatic load_all();
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            load_we = 1'b1; load_addr = {2'b00, 8'(a)}; load_data = mem_sh[a];
        end
        for (int r = 0; r < 16; r++) begin
            @(negedge clk);
            load_we = 1'b1; load_addr = {2'b01, 4'd0, 4'(r)}; load_data = {24'd0, creg_sh[r]};
            @(negedge clk);
            load_we = 1'b1; load_addr = {2'b10, 4'd0, 4'(r)}; load_data = {31'd0, freg_sh[r]};
        end
        @(negedge clk);
        load_we = 1'b0;
    endtask

    // behavioural reference of one instance
    task automatic model(input logic flag, output int cnt, output int lpc,
                         output int err, output int alus);
        int pc, nxt, cs_sel, ridx;
        int cstk[$];
        int lbody[$];
        int lleft[$];
        logic [31:0] w;
        logic cond;
        bit jumped, stop;
        pc = 0; cnt = 0; lpc = 0; err = 0; alus = 0; stop = 0;
        while (!stop) begin
            w = mem_sh[pc];
            cnt++;
            lpc = pc;
            if (w[31]) alus++;
            cs_sel = int'(w[27:26]);
            ridx   = int'(w[19:16]);
            case (cs_sel)
                0: cond = 1'b1;
                1: cond = flag;
                2: cond = freg_sh[ridx];
                default: cond = 1'b0;
            endcase
            cond   = cond ^ w[25];
            nxt    = (pc + 1) & 255;
            jumped = 0;
            case (int'(w[31:28]))
                1: if (cond) begin nxt = int'(w[7:0]); jumped = 1; end
                2: if (cond) begin
                    if (cstk.size() == 4) err = 1;
                    else begin cstk.push_back((pc + 1) & 255); nxt = int'(w[7:0]); jumped = 1; end
                end
                3: if (cstk.size() == 0) err = 1;
                   else begin nxt = cstk.pop_back(); jumped = 1; end
                4: if (lbody.size() == 4) err = 1;
                   else begin lbody.push_back((pc + 1) & 255); lleft.push_back(int'(creg_sh[ridx])); end
                5: if (lbody.size() == 0) err = 1;
                   else if (lleft[lleft.size()-1] == 0) begin
                       void'(lbody.pop_back()); void'(lleft.pop_back());
                   end else begin
                       lleft[lleft.size()-1] = lleft[lleft.size()-1] - 1;
                       nxt = lbody[lbody.size()-1];
                       jumped = 1;
                   end
                6: if (cond) stop = 1;
                default: ;
            endcase
            if (!jumped && pc == 255) stop = 1;
            if (cnt == BUDGET) stop = 1;
            if (err != 0) stop = 1;
            pc = nxt;
        end
    endtask

    task automatic run_batch(string req, logic [2:0] vv, logic [2:0] flags, bit poke);
        int cnt, lpc, err, alus, w;
        for (int i = 0; i < NV; i++) begin alu_seen[i] = 0; alu_badop[i] = 0; end
        alu_flag = flags;
        vertex_valid = vv;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk({req, " R10 busy after start"}, int'(busy), 1);
        if (poke) begin
            load_we = 1'b1; load_addr = 10'h100; load_data = 32'd5;
            @(negedge clk); load_we = 1'b0;
        end
        w = 0;
        while (!done && w < 100000) begin @(negedge clk); w++; end
        chk({req, " R10 done seen"}, int'(done), 1);
        chk({req, " R10 busy low at done"}, int'(busy), 0);
        @(negedge clk);
        chk({req, " R10 done one cycle"}, int'(done), 0);
        for (int i = 0; i < NV; i++) begin
            if (vv[i]) model(flags[i], cnt, lpc, err, alus);
            else begin cnt = 0; lpc = 0; err = 0; alus = 0; end
            chk({req, " R11 exec count"}, int'(exec_count[i*CW +: CW]), cnt);
            chk({req, " R11 last pc"}, int'(last_pc[i*8 +: 8]), lpc);
            chk({req, " R9 error"}, int'(error[i]), err);
            chk({req, " R3 alu issues"}, alu_seen[i], alus);
            chk({req, " R3 alu opcode class"}, alu_badop[i], 0);
        end
    endtask

    task automatic t_reset();
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 error", int'(error), 0);
        chk("R1 alu_valid", int'(alu_valid), 0);
        chk("R1 counts", int'(exec_count != '0), 0);
        chk("R1 last pc", int'(last_pc), 0);
    endtask

    task automatic t_alu_pass();
        clear_shadow(mk(6, 0, 0, 0, 0));
        mem_sh[0] = alu_w(1);
        mem_sh[1] = mk(0, 0, 0, 0, 0);
        mem_sh[2] = alu_w(7);
        mem_sh[3] = mk(7, 0, 0, 0, 0);
        mem_sh[4] = mk(6, 3, 0, 0, 0);
        mem_sh[5] = alu_w(3);
        load_all();
        run_batch("R3 R7", 3'b111, 3'b000, 0);
    endtask

    task automatic t_loop_full();
        clear_shadow(mk(6, 0, 0, 0, 0));
        creg_sh[2] = 8'd255;
        mem_sh[0] = mk(4, 0, 0, 2, 0);
        mem_sh[1] = alu_w(2);
        mem_sh[2] = mk(5, 0, 0, 0, 0);
        load_all();
        run_batch("R6 full", 3'b111, 3'b000, 0);
        chk("R6 256 passes", alu_seen[0], 256);
    endtask

    task automatic t_loop_nested();
        clear_shadow(mk(6, 0, 0, 0, 0));
        creg_sh[1] = 8'd2;
        creg_sh[3] = 8'd0;
        mem_sh[0] = mk(4, 0, 0, 1, 0);
        mem_sh[1] = mk(4, 0, 0, 3, 0);
        mem_sh[2] = alu_w(4);
        mem_sh[3] = mk(5, 0, 0, 0, 0);
        mem_sh[4] = mk(5, 0, 0, 0, 0);
        load_all();
        run_batch("R6 nested", 3'b111, 3'b000, 0);
        chk("R6 count zero runs once", alu_seen[1], 3);
    endtask

    task automatic t_branch_flag();
        clear_shadow(mk(6, 0, 0, 0, 0));
        mem_sh[0] = alu_w(5);
        mem_sh[1] = mk(1, 1, 0, 0, 4);
        mem_sh[2] = alu_w(6);
        mem_sh[3] = alu_w(6);
        load_all();
        run_batch("R4 R12 flag", 3'b111, 3'b101, 0);
        chk("R12 paths differ", int'(exec_count[0 +: CW] != exec_count[CW +: CW]), 1);
    endtask

    task automatic t_branch_freg();
        clear_shadow(mk(6, 0, 0, 0, 0));
        freg_sh[7] = 1'b1;
        mem_sh[0] = mk(1, 2, 1, 7, 9);
        mem_sh[1] = mk(1, 2, 0, 7, 3);
        mem_sh[2] = alu_w(1);
        mem_sh[3] = alu_w(2);
        mem_sh[4] = mk(1, 3, 0, 0, 0);
        mem_sh[5] = mk(1, 3, 1, 0, 8);
        mem_sh[8] = alu_w(3);
        load_all();
        run_batch("R4 freg", 3'b111, 3'b010, 0);
    endtask

    task automatic t_call();
        clear_shadow(mk(6, 0, 0, 0, 0));
        mem_sh[0]  = mk(2, 0, 0, 0, 10);
        mem_sh[10] = mk(2, 0, 0, 0, 20);  mem_sh[11] = mk(3, 0, 0, 0, 0);
        mem_sh[20] = mk(2, 0, 0, 0, 30);  mem_sh[21] = mk(3, 0, 0, 0, 0);
        mem_sh[30] = mk(2, 0, 0, 0, 40);  mem_sh[31] = mk(3, 0, 0, 0, 0);
        mem_sh[40] = alu_w(2);            mem_sh[41] = mk(3, 0, 0, 0, 0);
        mem_sh[1]  = mk(2, 1, 0, 0, 40);
        load_all();
        run_batch("R5 depth4", 3'b111, 3'b011, 0);
        chk("R5 no fault at depth 4", int'(error), 0);
    endtask

    task automatic t_stack_fault();
        clear_shadow(mk(6, 0, 0, 0, 0));
        for (int k = 0; k < 5; k++) mem_sh[k*10] = mk(2, 0, 0, 0, (k+1)*10);
        load_all();
        run_batch("R9 call overflow", 3'b111, 3'b000, 0);
        chk("R9 overflow flagged", int'(error), 7);
        clear_shadow(mk(6, 0, 0, 0, 0));
        for (int k = 0; k < 5; k++) mem_sh[k] = mk(4, 0, 0, 0, 0);
        load_all();
        run_batch("R9 loop overflow", 3'b011, 3'b000, 0);
        clear_shadow(mk(6, 0, 0, 0, 0));
        mem_sh[0] = alu_w(1);
        mem_sh[1] = mk(3, 0, 0, 0, 0);
        mem_sh[2] = mk(5, 0, 0, 0, 0);
        load_all();
        run_batch("R9 orphan return", 3'b111, 3'b000, 0);
        clear_shadow(mk(6, 0, 0, 0, 0));
        load_all();
        run_batch("R9 cleared", 3'b111, 3'b000, 0);
        chk("R9 cleared on start", int'(error), 0);
    endtask

    task automatic t_falloff();
        clear_shadow(mk(0, 0, 0, 0, 0));
        load_all();
        run_batch("R7 falloff", 3'b111, 3'b000, 0);
        chk("R7 last pc 255", int'(last_pc[7:0]), 255);
    endtask

    task automatic t_partial();
        clear_shadow(mk(6, 0, 0, 0, 0));
        mem_sh[0] = alu_w(2);
        mem_sh[1] = alu_w(3);
        load_all();
        run_batch("R10 partial", 3'b010, 3'b000, 0);
    endtask

    task automatic t_load_busy();
        clear_shadow(mk(6, 0, 0, 0, 0));
        creg_sh[0] = 8'd200;
        mem_sh[0] = mk(4, 0, 0, 0, 0);
        mem_sh[1] = mk(5, 0, 0, 0, 0);
        load_all();
        run_batch("R2 poke busy", 3'b111, 3'b000, 1);
        run_batch("R2 write ignored", 3'b111, 3'b000, 0);
        chk("R2 count kept 200", int'(exec_count[0 +: CW]), 1 + 201 + 1);
    endtask

    task automatic t_budget();
        clear_shadow(mk(6, 0, 0, 0, 0));
        mem_sh[0] = alu_w(1);
        mem_sh[1] = mk(1, 0, 0, 0, 0);
        load_all();
        run_batch("R8 budget", 3'b111, 3'b000, 0);
        chk("R8 count equals cap", int'(exec_count[2*CW +: CW]), BUDGET);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; vertex_valid = '0; load_we = 1'b0;
        load_addr = '0; load_data = '0; alu_flag = '0;
        for (int i = 0; i < NV; i++) begin alu_seen[i] = 0; alu_badop[i] = 0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_alu_pass();
        t_loop_full();
        t_loop_nested();
        t_branch_flag();
        t_branch_freg();
        t_call();
        t_stack_fault();
        t_falloff();
        t_partial();
        t_load_busy();
        t_budget();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule